// File: doc/BRIEF.md
# Signature-Marked Modulo Accumulator State Machine

This block is a small Mealy state machine whose specified behaviour is a modulo-4 accumulator. A 2-bit state adds each 2-bit input symbol, wraps around, and reports the wrap on a 1-bit output in the same cycle the symbol is presented. Every one of the sixteen state/symbol pairs already has a defined next state and output, so the functional table has no free entries.

To carry a hidden ownership mark without touching that table, the input is widened by one extension bit. While the extension bit is 0 the machine behaves exactly as specified. While it is 1, two extra transitions form a signature. Starting from the reset state, the owner applies symbol 00 and then symbol 11. The output then reads 1 and then 0, and the machine ends back in the reset state. Every other combination with the extension bit set is a filler entry: the state is held and the output is 0. The signature symbols and output bits are parameters, and the extension entries are produced by a generate loop.

Top module: `wm_accum_fsm`

## Requirements
- R1: A synchronous active-high reset puts the 2-bit state at 0 at the next rising clock edge, whatever the inputs are.
- R2: With the extension bit at 0, the next state is (state + symbol) mod 4. The symbol is read as an unsigned number 0 to 3.
- R3: With the extension bit at 0, the output is 1 exactly when state + symbol is 4 or more, and 0 otherwise. The output is combinational from the current state and inputs.
- R4: First signature step: in state 0 with the extension bit at 1 and symbol 00, the output is 1 and the next state is 1.
- R5: Second signature step: in state 1 with the extension bit at 1 and symbol 11, the output is 0 and the next state is 0.
- R6: Any other state/symbol pair with the extension bit at 1 keeps the current state and drives the output to 0.
- R7: Applying the two signature steps right after reset gives the output stream 1, 0. The machine is then in state 0 and resumes R2/R3 behaviour with no further reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sym_in | input | 2 | Input symbol |
| ext_sel | input | 1 | Extension bit; 1 selects the signature/filler entries |
| out_bit | output | 1 | Mealy output for the current state and inputs |

## Verification
The output is due in the same cycle as the symbol that causes it, before the next rising edge. A state change shows up only in the output for the symbol of the following cycle. The bench therefore drives inputs on the falling edge and samples out_bit 1 ns later, within the same cycle. A reference model advances its own state once per driven step. Each expected value is queued at the moment of driving and popped by a monitor at that sampling point. Hold and next-state effects are checked by follow-up probe symbols whose outputs depend on the state that was reached.

// File: rtl/wm_pkg.sv
package wm_pkg;

    // Source of the step taken in a cycle.
    typedef enum logic [1:0] {
        PATH_FUNC = 2'd0,
        PATH_MARK = 2'd1,
        PATH_FILL = 2'd2
    } path_e;

endpackage

// File: rtl/wm_func_step.sv
module wm_func_step #(
    parameter int ST_W = 2,
    parameter int IN_W = 2
) (
    input  logic [ST_W-1:0] cur,
    input  logic [IN_W-1:0] sym,
    output logic [ST_W-1:0] nxt,
    output logic            carry
);
    localparam int SUM_W = ST_W + 1;

    logic [SUM_W-1:0] sum;

    // Accumulate with one guard bit; the guard bit is the wrap flag.
    assign sum   = SUM_W'(cur) + SUM_W'(sym);
    assign nxt   = sum[ST_W-1:0];
    assign carry = sum[ST_W];

endmodule

// File: rtl/wm_mark_table.sv
module wm_mark_table #(
    parameter int                          ST_W    = 2,
    parameter int                          IN_W    = 2,
    parameter int                          SIG_LEN = 2,
    parameter logic [SIG_LEN*IN_W-1:0]     SIG_IN  = 4'b1100,
    parameter logic [SIG_LEN-1:0]          SIG_OUT = 2'b01
) (
    input  logic [ST_W-1:0] cur,
    input  logic [IN_W-1:0] sym,
    output logic            hit,
    output logic [ST_W-1:0] nxt,
    output logic            out
);
    logic [SIG_LEN-1:0] match;

    // Entry k sits in state k and expects signature symbol k.
    generate
        for (genvar k = 0; k < SIG_LEN; k++) begin : g_entry
            localparam logic [ST_W-1:0] K_STATE = ST_W'(k);
            localparam logic [IN_W-1:0] K_SYM   = SIG_IN[k*IN_W +: IN_W];
            assign match[k] = (cur == K_STATE) && (sym == K_SYM);
        end
    endgenerate

    always_comb begin
        hit = |match;
        nxt = '0;
        out = 1'b0;
        for (int k = 0; k < SIG_LEN; k++) begin
            if (match[k]) begin
                nxt = ST_W'((k + 1) % SIG_LEN);
                out = SIG_OUT[k];
            end
        end
    end

endmodule

// File: rtl/wm_accum_fsm.sv
module wm_accum_fsm
    import wm_pkg::*;
#(
    parameter int                          ST_W    = 2,
    parameter int                          IN_W    = 2,
    parameter int                          SIG_LEN = 2,
    parameter logic [SIG_LEN*IN_W-1:0]     SIG_IN  = 4'b1100,
    parameter logic [SIG_LEN-1:0]          SIG_OUT = 2'b01
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [IN_W-1:0] sym_in,
    input  logic            ext_sel,
    output logic            out_bit
);
    localparam int                 LAST     = SIG_LEN - 1;
    localparam logic [ST_W-1:0]    ST_FIRST = ST_W'(1 % SIG_LEN);
    localparam logic [ST_W-1:0]    ST_LAST  = ST_W'(LAST);

    typedef struct packed {
        logic [ST_W-1:0] state;
        logic            out;
    } step_t;

    logic [ST_W-1:0] state_q;
    step_t           step_d;
    path_e           path_sel;

    logic [ST_W-1:0] func_nxt;
    logic            func_carry;
    logic            mark_hit;
    logic [ST_W-1:0] mark_nxt;
    logic            mark_out;

    wm_func_step #(
        .ST_W (ST_W),
        .IN_W (IN_W)
    ) u_func (
        .cur   (state_q),
        .sym   (sym_in),
        .nxt   (func_nxt),
        .carry (func_carry)
    );

    wm_mark_table #(
        .ST_W    (ST_W),
        .IN_W    (IN_W),
        .SIG_LEN (SIG_LEN),
        .SIG_IN  (SIG_IN),
        .SIG_OUT (SIG_OUT)
    ) u_mark (
        .cur (state_q),
        .sym (sym_in),
        .hit (mark_hit),
        .nxt (mark_nxt),
        .out (mark_out)
    );

    always_comb begin
        if (!ext_sel)      path_sel = PATH_FUNC;
        else if (mark_hit) path_sel = PATH_MARK;
        else               path_sel = PATH_FILL;

        step_d = '{state: state_q, out: 1'b0};
        case (path_sel)
            PATH_FUNC: step_d = '{state: func_nxt, out: func_carry};
            PATH_MARK: step_d = '{state: mark_nxt, out: mark_out};
            default:   step_d = '{state: state_q, out: 1'b0};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= step_d.state;
    end

    assign out_bit = step_d.out;

    // R1: reset lands in state 0.
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> state_q == '0);

    // R2: functional step advances by the symbol, modulo the state range.
    a_r2_func_next: assert property (@(posedge clk) disable iff (rst)
        !ext_sel |=> state_q == ST_W'($past(state_q) + ST_W'($past(sym_in))));

    // R3: a wrap flag means the state went down, no flag means it did not.
    a_r3_wrap_down: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel && out_bit) |=> state_q < $past(state_q));
    a_r3_nowrap_up: assert property (@(posedge clk) disable iff (rst)
        (!ext_sel && !out_bit) |=> state_q >= $past(state_q));

    // R4: first signature entry.
    a_r4_mark_first: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && state_q == '0 && sym_in == SIG_IN[IN_W-1:0])
        |-> out_bit == SIG_OUT[0] ##1 state_q == ST_FIRST);

    // R5: last signature entry closes the loop to state 0.
    a_r5_mark_last: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && state_q == ST_LAST && sym_in == SIG_IN[LAST*IN_W +: IN_W])
        |-> out_bit == SIG_OUT[LAST] ##1 state_q == '0);

    // R6: filler entries hold the state and keep the output low.
    a_r6_fill_hold: assert property (@(posedge clk) disable iff (rst)
        (ext_sel && !mark_hit) |-> !out_bit ##1 state_q == $past(state_q));

endmodule

// File: tb/sim_wm_accum_fsm.sv
`timescale 1ns/1ps
module sim_wm_accum_fsm;

    typedef struct {
        bit    val;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sym_in = 2'b00;
    logic       ext_sel = 1'b0;
    logic       out_bit;

    int   total = 0;
    int   bad   = 0;
    bit   done  = 0;
    int   ms    = 0;      // reference state
    exp_t exp_q[$];

    always #2.5 clk = ~clk;   // 200 MHz

    wm_accum_fsm u0 (
        .clk     (clk),
        .rst     (rst),
        .sym_in  (sym_in),
        .ext_sel (ext_sel),
        .out_bit (out_bit)
    );

    // Driver: apply one cycle of inputs and queue the expected output.
    task automatic step(input bit r, input bit e, input int i, input string tag);
        exp_t x;
        int   nx;
        bit   o;
        @(negedge clk);
        rst = r; ext_sel = e; sym_in = 2'(i);
        if (!e) begin
            o  = (ms + i) >= 4;            // R3
            nx = (ms + i) % 4;             // R2
        end else if (ms == 0 && i == 0) begin
            o = 1'b1; nx = 1;              // R4
        end else if (ms == 1 && i == 3) begin
            o = 1'b0; nx = 0;              // R5
        end else begin
            o = 1'b0; nx = ms;             // R6
        end
        x.val = o; x.tag = tag;
        exp_q.push_back(x);
        ms = r ? 0 : nx;                   // R1
    endtask

    task automatic reach(input int s, input string tag);
        step(1, 0, 0, tag);
        if (s != 0) step(0, 0, s, tag);
    endtask

    // Monitor: sample 1 ns after the drive point, inside the same cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                total++;
                if (out_bit !== x.val) begin
                    bad++;
                    $display("FAIL %s: out_bit=%0b expected=%0b", x.tag, out_bit, x.val);
                end
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: finished=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Unchecked initial reset cycles.
        rst = 1'b1;
        repeat (2) @(negedge clk);
        ms = 0;

        // R1: reset state is 0: 0+3 no wrap, then 3+1 wraps.
        step(0, 0, 3, "R1");
        step(0, 0, 1, "R1");

        // R2 / R3: every specified pair, with probes of the next state.
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                reach(s, "R2");
                step(0, 0, i, "R3");
                step(0, 0, 3, "R2");
                step(0, 0, 2, "R2");
            end
        end

        // R7 with R4 and R5: signature replay from reset.
        step(1, 0, 0, "R7");
        step(0, 1, 0, "R4");
        step(0, 1, 3, "R5");
        step(0, 0, 3, "R7");   // state 0 -> 3, out 0
        step(0, 0, 1, "R7");   // 3+1 wraps, out 1

        // Signature steps out of order do not form the mark.
        step(1, 0, 0, "R6");
        step(0, 1, 3, "R6");   // state 0 with 11: filler
        step(0, 0, 3, "R6");   // still in 0: out 0

        // R6: every filler entry holds the state with output 0.
        for (int s = 0; s < 4; s++) begin
            for (int i = 0; i < 4; i++) begin
                if (!((s == 0 && i == 0) || (s == 1 && i == 3))) begin
                    reach(s, "R6");
                    step(0, 1, i, "R6");
                    step(0, 0, 2, "R6");
                    step(0, 0, 1, "R6");
                end
            end
        end

        // R1: reset in mid-run, while the output is a wrap.
        reach(3, "R1");
        step(1, 0, 2, "R1");
        step(0, 0, 3, "R1");
        step(0, 0, 1, "R1");

        // Mixed random traffic.
        for (int n = 0; n < 400; n++) begin
            step(0, ($urandom_range(0, 3) == 0), int'($urandom_range(0, 3)), "R2");
        end

        @(negedge clk);
        #2;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule